// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block sits behind a host I/O bus and exposes two byte-wide ports: an index port that selects a configuration register and a data port that reads or writes it. It ignores configuration traffic until software writes a two-byte unlock key to the index port. A different two-byte key written to the index port locks it again. While unlocked, software reaches a small global register file and one register bank per logical device. A device-number register chooses which bank the data port addresses.

The block drives configuration outputs to two serial-port logical devices and one watchdog logical device. These outputs are an activate flag per device, and an aligned I/O base and an interrupt line number per serial device. It also holds the global interrupt-enable bit. It contains the UART clock predivider, which turns the system clock into a single-cycle clock-enable pulse at a ratio picked by a two-bit global field. Host accesses are modelled as one-cycle write and read strobes with a port select bit (0 = index port, 1 = data port).

Top module: `cfg_port_ctrl`

## Requirements
- R1: Writing 0x80 and then 0x86 as consecutive index-port writes sets `cfg_open` at the clock edge that takes the second byte.
- R2: While locked, any other byte breaks a partial unlock sequence. A byte of 0x80 always counts as a fresh first key byte, so 0x80, 0x80, 0x86 unlocks and 0x80, 0x55, 0x86 does not.
- R3: While unlocked, consecutive index-port writes of 0x68 and then 0x08 clear `cfg_open`. A repeated 0x68 counts as a fresh first exit byte.
- R4: While locked, index-port and data-port writes change no register and no output, and every read returns 0xFF.
- R5: While unlocked, an index-port write selects a register and an index-port read returns that index. Index 0x07 holds the logical device number. Reads of unmapped indices return 0x00. Read data appears on `host_rdata` in the cycle after the read strobe and is held until the next read.
- R6: Global register 0x29 maps bit 0 to `irq_en` and bits [3:2] to `prediv_sel`. Its other bits read back as 0.
- R7: Device numbers 0x04 and 0x05 select serial devices 0 and 1, and 0x06 selects the watchdog. Bit 0 of index 0x30 in the selected bank drives that device's bit of `dev_active`. For any other device number, bank writes are ignored and bank reads return 0x00.
- R8: For a serial device, index 0x60 holds base bits [15:8] and index 0x61 holds bits [7:0]. The base is masked with 0x07F8. Index 0x70 holds the interrupt number in its low 4 bits.
- R9: Writes to a serial device's base or interrupt registers are ignored while that device is active.
- R10: `uart_tick` is a one-cycle pulse with period 1, 8 or 26 cycles for `prediv_sel` 00, 01 or 10. The reserved code 11 acts as divide by 1.
- R11: A change of `prediv_sel` restarts the divider. The first pulse at the new ratio N comes N+1 clock edges after the edge that wrote the new value.
- R12: After reset the block is locked, all devices are inactive, bases and interrupt numbers are zero, `irq_en` is 0 and `prediv_sel` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | One-cycle byte write strobe |
| host_rd | input | 1 | One-cycle byte read strobe |
| host_port | input | 1 | Port select: 0 index port, 1 data port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Registered read byte |
| cfg_open | output | 1 | Configuration mode unlocked |
| irq_en | output | 1 | Global device interrupt enable |
| prediv_sel | output | 2 | UART clock predivide code |
| uart_tick | output | 1 | Predivided clock-enable pulse |
| dev_active | output | 3 | Activate flags: bit 0 serial 0, bit 1 serial 1, bit 2 watchdog |
| ser_base | output | 32 | Serial I/O bases, serial 0 in bits [15:0] |
| ser_irq | output | 8 | Serial interrupt numbers, serial 0 in bits [3:0] |

## Verification
A key tracker left in the wrong state shows as `cfg_open` moving on the wrong byte. It also shows as reads that return 0xFF when they should not, or fail to, starting in the cycle after the offending write. A wrong device-number or bank state shows on the next data-port read of that bank and at once on `dev_active`, `ser_base` or `ser_irq`. Divider count errors show on `uart_tick` within one period of the new ratio, because the first pulse after a ratio change lands on a fixed edge.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam logic [7:0] KEY_ON_A   = 8'h80;
  localparam logic [7:0] KEY_ON_B   = 8'h86;
  localparam logic [7:0] KEY_OFF_A  = 8'h68;
  localparam logic [7:0] KEY_OFF_B  = 8'h08;

  localparam logic [7:0] IDX_LDN     = 8'h07;
  localparam logic [7:0] IDX_GLOBAL  = 8'h29;
  localparam logic [7:0] IDX_ACT     = 8'h30;
  localparam logic [7:0] IDX_BASE_HI = 8'h60;
  localparam logic [7:0] IDX_BASE_LO = 8'h61;
  localparam logic [7:0] IDX_IRQ     = 8'h70;

  localparam int          LDN_FIRST  = 4;
  localparam int          BASE_W     = 16;
  localparam logic [15:0] BASE_MASK  = 16'h07F8;
endpackage

// File: rtl/cfg_key_tracker.sv
module cfg_key_tracker
  import cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      open  <= 1'b0;
      armed <= 1'b0;
    end else if (idx_wr) begin
      if (!open) begin
        if (armed && wdata == KEY_ON_B) begin
          open  <= 1'b1;
          armed <= 1'b0;
        end else begin
          armed <= (wdata == KEY_ON_A);
        end
      end else begin
        if (armed && wdata == KEY_OFF_B) begin
          open  <= 1'b0;
          armed <= 1'b0;
        end else begin
          armed <= (wdata == KEY_OFF_A);
        end
      end
    end
  end

  // R1: opening only ever follows the second unlock byte
  p_open_on_key_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(open) |-> $past(idx_wr && wdata == KEY_ON_B));
  // R3: closing only ever follows the second exit byte
  p_close_on_key_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(open) |-> $past(idx_wr && wdata == KEY_OFF_B));
  // R4: without an index write the mode cannot change
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !idx_wr |=> $stable(open));
endmodule

// File: rtl/cfg_prediv.sv
module cfg_prediv #(
  parameter int DIV_B = 8,
  parameter int DIV_C = 26
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int CW = $clog2(DIV_C + 1);

  logic [1:0]    sel_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb begin
    case (sel)
      2'b01:   last = CW'(DIV_B - 1);
      2'b10:   last = CW'(DIV_C - 1);
      default: last = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 2'b00;
      cnt   <= '0;
      tick  <= 1'b0;
    end else begin
      sel_q <= sel;
      if (sel != sel_q) begin
        cnt  <= '0;
        tick <= 1'b0;
      end else if (cnt == last) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end
  end

  // R11: a ratio change suppresses the pulse while the count restarts
  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel) |=> !tick);
  // R10: divide-by-one codes pulse every cycle once settled
  p_div_one_r10: assert property (@(posedge clk) disable iff (rst)
    (sel == 2'b00 || sel == 2'b11) && $stable(sel) |=> tick);
  // R10: a pulse never lasts two cycles at the larger ratios
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    tick && (sel == 2'b01 || sel == 2'b10) && $stable(sel) |=> !tick);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_pkg::*;
#(
  parameter int NUM_SERIAL = 2,
  parameter int IRQ_W      = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         open,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic                         host_port,
  input  logic [7:0]                   wdata,
  output logic [7:0]                   rdata,
  output logic                         intr_en,
  output logic [1:0]                   prediv,
  output logic [NUM_SERIAL:0]          dev_active,
  output logic [NUM_SERIAL*BASE_W-1:0] ser_base,
  output logic [NUM_SERIAL*IRQ_W-1:0]  ser_irq
);
  localparam int NUM_DEV = NUM_SERIAL + 1;

  logic [7:0]        index_q;
  logic [7:0]        ldn_q;
  logic [7:0]        rd_val;
  logic [NUM_DEV-1:0] dev_sel;
  logic [BASE_W-1:0] base_q [NUM_SERIAL];
  logic [IRQ_W-1:0]  irq_q  [NUM_SERIAL];

  wire idx_wr = host_wr & ~host_port & open;
  wire dat_wr = host_wr &  host_port & open;

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
      ldn_q   <= '0;
      intr_en <= 1'b0;
      prediv  <= 2'b00;
    end else begin
      if (idx_wr) index_q <= wdata;
      if (dat_wr && index_q == IDX_LDN) ldn_q <= wdata;
      if (dat_wr && index_q == IDX_GLOBAL) begin
        intr_en <= wdata[0];
        prediv  <= wdata[3:2];
      end
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign dev_sel[g] = (ldn_q == 8'(LDN_FIRST + g));

    always_ff @(posedge clk) begin
      if (rst)                                       dev_active[g] <= 1'b0;
      else if (dat_wr && dev_sel[g] && index_q == IDX_ACT) dev_active[g] <= wdata[0];
    end

    if (g < NUM_SERIAL) begin : g_ser
      wire bank_wr = dat_wr & dev_sel[g] & ~dev_active[g];

      always_ff @(posedge clk) begin
        if (rst) begin
          base_q[g] <= '0;
          irq_q[g]  <= '0;
        end else if (bank_wr) begin
          if (index_q == IDX_BASE_HI) base_q[g][15:8] <= wdata & BASE_MASK[15:8];
          if (index_q == IDX_BASE_LO) base_q[g][7:0]  <= wdata & BASE_MASK[7:0];
          if (index_q == IDX_IRQ)     irq_q[g]        <= wdata[IRQ_W-1:0];
        end
      end

      assign ser_base[g*BASE_W +: BASE_W] = base_q[g];
      assign ser_irq[g*IRQ_W +: IRQ_W]    = irq_q[g];

      // R9: an active device keeps its base and interrupt settings
      p_bank_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        $past(dev_active[g]) |-> $stable(base_q[g]) && $stable(irq_q[g]));
    end
  end

  always_comb begin
    rd_val = 8'h00;
    case (index_q)
      IDX_LDN:    rd_val = ldn_q;
      IDX_GLOBAL: rd_val = {4'b0000, prediv, 1'b0, intr_en};
      IDX_ACT:    rd_val = {7'b0, |(dev_sel & dev_active)};
      IDX_BASE_HI: for (int i = 0; i < NUM_SERIAL; i++)
                     if (dev_sel[i]) rd_val = base_q[i][15:8];
      IDX_BASE_LO: for (int i = 0; i < NUM_SERIAL; i++)
                     if (dev_sel[i]) rd_val = base_q[i][7:0];
      IDX_IRQ:     for (int i = 0; i < NUM_SERIAL; i++)
                     if (dev_sel[i]) rd_val = 8'(irq_q[i]);
      default:    rd_val = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= 8'h00;
    else if (host_rd) rdata <= !open ? 8'hFF : (host_port ? rd_val : index_q);
  end

  // R4: locked reads return all ones
  p_locked_read_r4: assert property (@(posedge clk) disable iff (rst)
    host_rd && !open |=> rdata == 8'hFF);
  // R4: locked cycles leave the global settings untouched
  p_locked_global_r4: assert property (@(posedge clk) disable iff (rst)
    !open |=> $stable(intr_en) && $stable(prediv) && $stable(dev_active));
  // R5: read data is held between read strobes
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> $stable(rdata));
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_pkg::*;
#(
  parameter int NUM_SERIAL = 2,
  parameter int IRQ_W      = 4,
  parameter int DIV_B      = 8,
  parameter int DIV_C      = 26
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         host_wr,
  input  logic                         host_rd,
  input  logic                         host_port,
  input  logic [7:0]                   host_wdata,
  output logic [7:0]                   host_rdata,
  output logic                         cfg_open,
  output logic                         irq_en,
  output logic [1:0]                   prediv_sel,
  output logic                         uart_tick,
  output logic [NUM_SERIAL:0]          dev_active,
  output logic [NUM_SERIAL*BASE_W-1:0] ser_base,
  output logic [NUM_SERIAL*IRQ_W-1:0]  ser_irq
);
  cfg_key_tracker i_key (
    .clk    (clk),
    .rst    (rst),
    .idx_wr (host_wr & ~host_port),
    .wdata  (host_wdata),
    .open   (cfg_open)
  );

  cfg_regs #(.NUM_SERIAL(NUM_SERIAL), .IRQ_W(IRQ_W)) i_regs (
    .clk        (clk),
    .rst        (rst),
    .open       (cfg_open),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_port  (host_port),
    .wdata      (host_wdata),
    .rdata      (host_rdata),
    .intr_en    (irq_en),
    .prediv     (prediv_sel),
    .dev_active (dev_active),
    .ser_base   (ser_base),
    .ser_irq    (ser_irq)
  );

  cfg_prediv #(.DIV_B(DIV_B), .DIV_C(DIV_C)) i_div (
    .clk  (clk),
    .rst  (rst),
    .sel  (prediv_sel),
    .tick (uart_tick)
  );
endmodule

// File: tb/test_cfg_port_ctrl.sv
`timescale 1ns/1ps
module test_cfg_port_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0, host_port = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        cfg_open, irq_en, uart_tick;
  logic [1:0]  prediv_sel;
  logic [2:0]  dev_active;
  logic [31:0] ser_base;
  logic [7:0]  ser_irq;

  int n_run = 0, n_fail = 0;

  logic        m_act [3];
  logic [15:0] m_base [2];
  logic [3:0]  m_irq [2];
  logic        m_int;
  logic [1:0]  m_pre;
  logic [7:0]  m_ldn;

  always #4 clk = ~clk;

  cfg_port_ctrl i_cfg_port_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd), .host_port(host_port),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cfg_open(cfg_open), .irq_en(irq_en),
    .prediv_sel(prediv_sel), .uart_tick(uart_tick), .dev_active(dev_active),
    .ser_base(ser_base), .ser_irq(ser_irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic p, input logic [7:0] v);
    @(negedge clk); host_wr = 1'b1; host_port = p; host_wdata = v;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic p, output logic [7:0] v);
    @(negedge clk); host_rd = 1'b1; host_port = p;
    @(negedge clk); host_rd = 1'b0; v = host_rdata;
  endtask

  task automatic reg_rd(input logic [7:0] ix, output logic [7:0] v);
    wr(0, ix); rd(1, v);
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] ix);
    int d = int'(m_ldn) - 4;
    case (ix)
      8'h07: return m_ldn;
      8'h29: return {4'b0, m_pre, 1'b0, m_int};
      8'h30: return (d >= 0 && d < 3) ? {7'b0, m_act[d]} : 8'h00;
      8'h60: return (d >= 0 && d < 2) ? m_base[d][15:8] : 8'h00;
      8'h61: return (d >= 0 && d < 2) ? m_base[d][7:0]  : 8'h00;
      8'h70: return (d >= 0 && d < 2) ? {4'b0, m_irq[d]} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mdl_wr(input logic [7:0] ix, input logic [7:0] v);
    int d = int'(m_ldn) - 4;
    wr(0, ix); wr(1, v);
    case (ix)
      8'h07: m_ldn = v;
      8'h29: begin m_int = v[0]; m_pre = v[3:2]; end
      8'h30: if (d >= 0 && d < 3) m_act[d] = v[0];
      8'h60: if (d >= 0 && d < 2 && !m_act[d]) m_base[d][15:8] = v & 8'h07;
      8'h61: if (d >= 0 && d < 2 && !m_act[d]) m_base[d][7:0]  = v & 8'hF8;
      8'h70: if (d >= 0 && d < 2 && !m_act[d]) m_irq[d] = v[3:0];
      default: ;
    endcase
  endtask

  task automatic check_ports(input string req);
    chk(req, {29'b0, dev_active}, {29'b0, m_act[2], m_act[1], m_act[0]});
    chk(req, ser_base, {m_base[1], m_base[0]});
    chk(req, {24'b0, ser_irq}, {24'b0, m_irq[1], m_irq[0]});
    chk(req, {29'b0, prediv_sel, irq_en}, {29'b0, m_pre, m_int});
  endtask

  task automatic count_ticks(input logic [1:0] sel, input int exp);
    int n = 0;
    mdl_wr(8'h29, {4'b0, sel, 2'b00});
    repeat (4) @(negedge clk);
    for (int i = 0; i < 208; i++) begin
      @(negedge clk);
      if (uart_tick) n++;
    end
    chk("R10 tick count", n, exp);
  endtask

  logic [7:0] v;

  initial begin
    for (int i = 0; i < 3; i++) m_act[i] = 1'b0;
    for (int i = 0; i < 2; i++) begin m_base[i] = '0; m_irq[i] = '0; end
    m_int = 1'b0; m_pre = 2'b00; m_ldn = 8'h00;
    v = $urandom(32'h00C0FFEE);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    chk("R12 locked", cfg_open, 1'b0);
    check_ports("R12 outputs");
    // R4 locked reads and writes
    rd(1, v); chk("R4 locked data read", v, 8'hFF);
    rd(0, v); chk("R4 locked index read", v, 8'hFF);
    wr(0, 8'h29); wr(1, 8'h0D);
    check_ports("R4 locked write ignored");

    // R2 broken sequence, then restart on repeated first byte
    wr(0, 8'h80); wr(0, 8'h55); wr(0, 8'h86);
    chk("R2 broken key", cfg_open, 1'b0);
    wr(0, 8'h86);
    chk("R2 lone second byte", cfg_open, 1'b0);
    wr(0, 8'h80); wr(0, 8'h80); wr(0, 8'h86);
    chk("R2 restart on 0x80", cfg_open, 1'b1);

    // R3 exit key with repeated first byte
    wr(0, 8'h68); wr(0, 8'h68); wr(0, 8'h08);
    chk("R3 relock", cfg_open, 1'b0);
    rd(1, v); chk("R3 read after relock", v, 8'hFF);

    // R1 direct unlock, observed the cycle after the second byte
    wr(0, 8'h80);
    @(negedge clk); host_wr = 1'b1; host_port = 1'b0; host_wdata = 8'h86;
    @(negedge clk); host_wr = 1'b0;
    chk("R1 unlock", cfg_open, 1'b1);

    // R5 index readback and unmapped read
    wr(0, 8'h55); rd(0, v); chk("R5 index read", v, 8'h55);
    rd(1, v); chk("R5 unmapped read", v, 8'h00);
    mdl_wr(8'h07, 8'h04);
    reg_rd(8'h07, v); chk("R5 ldn read", v, 8'h04);

    // R6 global register
    mdl_wr(8'h29, 8'hFF);
    reg_rd(8'h29, v); chk("R6 global read", v, 8'h0D);
    check_ports("R6 global outputs");

    // R8 base masking and interrupt number
    mdl_wr(8'h60, 8'hFF); mdl_wr(8'h61, 8'hFF); mdl_wr(8'h70, 8'h7A);
    chk("R8 base masked", ser_base[15:0], 16'h07F8);
    reg_rd(8'h61, v); chk("R8 base low read", v, 8'hF8);
    reg_rd(8'h70, v); chk("R8 irq read", v, 8'h0A);

    // R9 frozen while active
    mdl_wr(8'h30, 8'h01);
    mdl_wr(8'h60, 8'h03); mdl_wr(8'h61, 8'h10); mdl_wr(8'h70, 8'h03);
    chk("R9 base frozen", ser_base[15:0], 16'h07F8);
    chk("R9 irq frozen", {28'b0, ser_irq[3:0]}, 32'hA);

    // R7 watchdog bank and out-of-range device
    mdl_wr(8'h07, 8'h06); mdl_wr(8'h30, 8'h01);
    chk("R7 watchdog active", {29'b0, dev_active}, 32'h5);
    mdl_wr(8'h07, 8'h07); mdl_wr(8'h30, 8'h01);
    reg_rd(8'h30, v); chk("R7 no bank read", v, 8'h00);
    check_ports("R7 no bank write");

    // R10 ratios including reserved code
    count_ticks(2'b00, 208);
    count_ticks(2'b01, 26);
    count_ticks(2'b10, 8);
    count_ticks(2'b11, 208);

    // R11 restart: first pulse N+1 edges after the writing edge
    mdl_wr(8'h29, 8'h08);
    repeat (11) @(negedge clk);
    wr(0, 8'h29);
    @(negedge clk); host_wr = 1'b1; host_port = 1'b1; host_wdata = 8'h04;
    @(negedge clk); host_wr = 1'b0; m_pre = 2'b01; m_int = 1'b0;
    begin
      int k = 0;
      while (!uart_tick && k < 40) begin @(negedge clk); k++; end
      chk("R11 first pulse", k, 9);
    end

    // random bank traffic while unlocked (R5 R7 R8 R9)
    for (int i = 0; i < 80; i++) begin
      logic [7:0] ix;
      case ($urandom_range(0, 4))
        0: ix = 8'h30; 1: ix = 8'h60; 2: ix = 8'h61; 3: ix = 8'h70; default: ix = 8'h07;
      endcase
      if (ix == 8'h07) mdl_wr(ix, 8'($urandom_range(3, 7)));
      else             mdl_wr(ix, 8'($urandom));
      reg_rd(ix, v); chk("R8 random readback", v, exp_rd(ix));
    end
    check_ports("R9 random ports");

    // random locked traffic (R4)
    wr(0, 8'h68); wr(0, 8'h08);
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b = 8'($urandom);
      if (b == 8'h80) b = 8'h81;
      wr(1'($urandom), b);
    end
    chk("R4 still locked", cfg_open, 1'b0);
    check_ports("R4 random locked");
    wr(0, 8'h80); wr(0, 8'h86);
    foreach (m_act[i]) begin
      if (i < 3) begin
        mdl_wr(8'h07, 8'(4 + i));
        reg_rd(8'h30, v); chk("R4 bank kept", v, exp_rd(8'h30));
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule